// File: doc/BRIEF.md
# Serial EEPROM Read-Burst Emulator

This block stands in for a serial EEPROM on an I2C bus. Its only job is to answer one fixed sequential-read burst. That way a host can hand a stored program image to a DSP that loads its program over I2C at power-up or on request. A pulse on `start` toggles the `notify` line, which tells the master to fetch a new program. The same pulse arms the block to follow the master's clock.

The block does not decode the protocol. It does not look for START or STOP conditions, and it never checks the slave address or the word address. It counts falling edges of the synchronized SCL instead:

- **Header phase:** a fixed run of header edges. The block acknowledges at four fixed edge numbers.
- **Data phase:** a fixed number of bytes, sent MSB first, with a released slot after each byte for the master's acknowledge. The bytes come from a buffer outside the block through a read port with one cycle of latency. The block drives SDA only as an open-drain pull-down enable.

Top module: `eeprom_stream_slave`

## Requirements
- R1: A `start` pulse seen while `busy` is low inverts `notify` once. From the next cycle on, `busy` is high.
- R2: `sda_oe` = 1 means the line is pulled low and `sda_oe` = 0 means it is released. A data bit of 0 therefore shows as `sda_oe` = 1, and a data bit of 1 as `sda_oe` = 0.
- R3: `sda_oe` changes only on the third system clock edge after SCL goes from high to low. It holds steady while SCL is high.
- R4: The first 37 SCL falling edges after arming form the header, numbered from 0. The block pulls SDA low on edges 8, 17, 26 and 36, and releases it on every other header edge.
- R5: After the header, each byte read at `rd_addr` is sent MSB first, one bit per falling edge. `rd_data` is taken as valid one cycle after `rd_addr` changes.
- R6: The ninth falling edge of each byte releases SDA for the master's acknowledge. On that same edge `rd_addr` moves to the next byte, whatever the master answers.
- R7: After the release slot of byte BYTES-1 (BYTES = 512 by default):
  - `sda_oe` is 0;
  - `busy` falls;
  - `done` is high for exactly one cycle;
  - `rd_addr` returns to 0.
- R8: A `start` pulse seen while `busy` is high leaves `notify` unchanged and does not disturb the burst in progress.
- R9: After reset, `sda_oe`, `notify`, `busy`, `done` and `rd_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to load a new program |
| scl_in | input | 1 | I2C clock from the master, asynchronous |
| notify | output | 1 | Level that toggles once per accepted request |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_addr | output | $clog2(BYTES) | Byte address into the program buffer |
| rd_data | input | 8 | Buffer byte, valid one cycle after rd_addr |
| busy | output | 1 | High from an accepted start until the burst ends |
| done | output | 1 | One-cycle pulse when the burst completes |

## Verification
The bench uses the default BYTES = 512. It runs two full bursts, each with different buffer contents, so every address, the wrap of `rd_addr` back to zero and a second toggle of `notify` are all exercised. SCL runs at eight system cycles per period. This puts each SDA update inside the low phase with time to spare, so the bench can check that the line stays stable through the whole high phase. A request made partway through the header checks that a start while busy is ignored.

// File: rtl/eeprom_stream_slave.sv
module eeprom_stream_slave #(
  parameter int BYTES = 512,
  localparam int AW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          scl_in,
  output logic          notify,
  output logic          sda_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done
);

  localparam int HDR_EDGES = 37;
  localparam logic [5:0] ACK_A = 6'd8;
  localparam logic [5:0] ACK_B = 6'd17;
  localparam logic [5:0] ACK_C = 6'd26;
  localparam logic [5:0] ACK_D = 6'(HDR_EDGES - 1);
  localparam logic [AW-1:0] LAST = AW'(BYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} state_t;

  state_t      state;
  logic [2:0]  scl_q;
  logic [5:0]  hcnt;
  logic [3:0]  bcnt;
  logic [7:0]  cur_byte;
  logic [1:0]  fetch;
  logic        scl_fall;
  logic        hdr_ack;

  assign scl_fall = scl_q[2] & ~scl_q[1];
  assign hdr_ack  = (hcnt == ACK_A) || (hcnt == ACK_B) || (hcnt == ACK_C) || (hcnt == ACK_D);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 3'b111;
    else        scl_q <= {scl_q[1:0], scl_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_byte <= '0;
      fetch    <= '0;
    end else begin
      fetch <= {fetch[0], 1'b0};
      if (fetch[1]) cur_byte <= rd_data;
      if (state == ST_IDLE && start) fetch[0] <= 1'b1;
      if (state == ST_DATA && scl_fall && bcnt == 4'd8 && rd_addr != LAST) fetch[0] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      notify  <= 1'b0;
      sda_oe  <= 1'b0;
      rd_addr <= '0;
      hcnt    <= '0;
      bcnt    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          sda_oe <= 1'b0;
          if (start) begin
            notify  <= ~notify;
            state   <= ST_HDR;
            hcnt    <= '0;
            bcnt    <= '0;
            rd_addr <= '0;
          end
        end
        ST_HDR: if (scl_fall) begin
          sda_oe <= hdr_ack;
          hcnt   <= hcnt + 6'd1;
          if (hcnt == ACK_D) state <= ST_DATA;
        end
        ST_DATA: if (scl_fall) begin
          if (bcnt != 4'd8) begin
            sda_oe <= ~cur_byte[3'd7 - bcnt[2:0]];
            bcnt   <= bcnt + 4'd1;
          end else begin
            sda_oe <= 1'b0;
            bcnt   <= '0;
            if (rd_addr == LAST) begin
              rd_addr <= '0;
              state   <= ST_IDLE;
              done    <= 1'b1;
            end else begin
              rd_addr <= rd_addr + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_notify_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (notify != $past(notify)) && busy);

  assert_sda_only_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |=> $stable(sda_oe));

  assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe);

  assert_done_ends_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && rd_addr == '0 && $past(busy));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(notify));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(rd_addr)) |-> (rd_addr == $past(rd_addr) + 1'b1) || done);

endmodule

// File: tb/eeprom_stream_slave_bench.sv
module eeprom_stream_slave_bench;
  localparam int BYTES = 512;
  localparam int AW = $clog2(BYTES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scl_in = 1'b1;
  logic notify, sda_oe, busy, done;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data;
  logic [7:0] mem [BYTES];
  logic sda_line;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  int edge_no;

  always #5 clk = ~clk;

  always_ff @(posedge clk) rd_data <= mem[rd_addr];
  assign sda_line = sda_oe ? 1'b0 : 1'b1;

  eeprom_stream_slave #(.BYTES(BYTES)) u_eeprom_stream_slave (
    .clk(clk), .rst_n(rst_n), .start(start), .scl_in(scl_in),
    .notify(notify), .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s edge %0d: actual %0d expected %0d", req, edge_no, act, exp);
    end
  endtask

  task automatic scl_edge(input bit exp_oe, input string req, input bit last,
                          input int exp_addr, input bit chk_addr);
    @(negedge clk) scl_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(sda_oe == exp_oe, req, sda_oe, exp_oe);
    chk(sda_line == !exp_oe, "R2", sda_line, !exp_oe);
    chk(done == last, "R7 done", done, last);
    chk(busy == !last, "R7 busy", busy, !last);
    if (chk_addr) chk(rd_addr == exp_addr, "R6 addr", rd_addr, exp_addr);
    @(negedge clk);
    chk(done == 1'b0, "R7 pulse", done, 0);
    scl_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(sda_oe == exp_oe, "R3 stable", sda_oe, exp_oe);
    end
    edge_no++;
  endtask

  task automatic burst(input bit mid_start);
    logic n0;
    n0 = notify;
    edge_no = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(notify == !n0, "R1 toggle", notify, !n0);
    chk(busy == 1'b1, "R1 busy", busy, 1);
    for (int k = 0; k < 37; k++) begin
      bit ack;
      ack = (k == 8) || (k == 17) || (k == 26) || (k == 36);
      if (mid_start && k == 20) begin
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (2) @(negedge clk);
        chk(notify == !n0, "R8 notify", notify, !n0);
        chk(busy == 1'b1, "R8 busy", busy, 1);
      end
      scl_edge(ack, "R4 header", 1'b0, 0, 1'b0);
    end
    for (int b = 0; b < BYTES; b++) begin
      for (int j = 7; j >= 0; j--) scl_edge(!mem[b][j], "R5 data", 1'b0, b, 1'b1);
      scl_edge(1'b0, "R6 release", b == BYTES - 1, (b == BYTES - 1) ? 0 : b + 1, 1'b1);
    end
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && sda_oe == 1'b0, "R7 idle", {busy, sda_oe}, 0);
  endtask

  initial begin
    for (int i = 0; i < BYTES; i++) mem[i] = 8'((i * 37 + 5) ^ (i >> 2));
    mem[0] = 8'hA5;
    mem[BYTES-1] = 8'h3C;
    repeat (3) @(negedge clk);
    chk(sda_oe == 0 && notify == 0 && busy == 0 && done == 0 && rd_addr == 0,
        "R9 reset", {sda_oe, notify, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    @(negedge clk) scl_in = 1'b0;
    repeat (4) @(negedge clk);
    scl_in = 1'b1;
    repeat (2) @(negedge clk);
    chk(sda_oe == 0 && busy == 0, "R7 idle ignores scl", sda_oe, 0);
    burst(1'b1);
    for (int i = 0; i < BYTES; i++) mem[i] = ~mem[i] ^ 8'(i);
    repeat (5) @(negedge clk);
    burst(1'b0);
    chk(notify == 1'b0, "R1 second toggle", notify, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule